// File: doc/BRIEF.md
# RAM Bank Configuration Latch

This block watches the processor's I/O write cycles and keeps a 3-bit RAM configuration for a machine with a base 64 KB DRAM bank and a second 64 KB bank. The video controller uses the same I/O port. This block takes a write only when the two top data bits are both set. Every other data value on that port belongs to the video controller and leaves the configuration unchanged.

For every DRAM access, the block uses the held configuration and the processor's two top address bits to produce two things: the DRAM page address bits and the column strobe for the selected bank. Video fetches bypass the remapping and always read the base bank. Everything is synchronous to one clock. The input column strobe is sampled and returned as a registered, bank-steered strobe one clock later.

Top module: `ram_bank_latch`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the configuration is 0, both bank strobes are high and the page outputs are 00.
- R2: A configuration write is a clock edge at which `wr_n` is high after being low at the previous edge, with `iorq_n` low, `cpu_addr_hi` = 2'b01 and `cpu_data[7:6]` = 2'b11. It loads `cpu_data[2:0]`, and accesses sampled at later edges use the new value.
- R3: A write to the port with `cpu_data[7:6]` other than 2'b11 leaves the configuration unchanged.
- R4: A write with `cpu_addr_hi` other than 2'b01, or with `iorq_n` high, leaves the configuration unchanged.
- R5: `cpu_data[5:3]` has no effect. Data values 0xC0 to 0xFF give configuration `cpu_data[2:0]`.
- R6: For a processor access to page p = `cpu_addr_hi`, the {bank, page} result is as follows:
  - config 0: base p.
  - config 1: page 3 goes to extra 3; other pages go to base p.
  - config 2: extra p.
  - config 3: page 1 goes to base 3, page 3 goes to extra 3, pages 0 and 2 go to base p.
  - configs 4 to 7: page 1 goes to extra (config-4); other pages go to base p.

  The base bank drives `cas_base_n` low, the extra bank drives `cas_ext_n` low, and `{dram_a15,dram_a14}` carries the page.
- R7: With `vid_fetch` high, the access goes to base page `cpu_addr_hi`, whatever the configuration.
- R8: With `ram_off` high, both bank strobes stay high.
- R9: With `cas_n` high, both strobes stay high. All outputs are registered and reflect the inputs sampled at the previous clock edge.
- R10: The two bank strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr_hi | input | 2 | Processor address bits 15:14 |
| cpu_data | input | 8 | Processor data bus |
| iorq_n | input | 1 | I/O request, active low |
| wr_n | input | 1 | Write strobe, active low |
| cas_n | input | 1 | Column strobe from timing logic, active low |
| ram_off | input | 1 | RAM disable, blocks both bank strobes |
| vid_fetch | input | 1 | High for a video fetch cycle |
| dram_a15 | output | 1 | Remapped DRAM page bit 1 |
| dram_a14 | output | 1 | Remapped DRAM page bit 0 |
| cas_base_n | output | 1 | Column strobe for the base bank |
| cas_ext_n | output | 1 | Column strobe for the extra bank |

## Verification
The configuration cannot be read back, so a dropped or wrongly accepted write can only be seen indirectly, in the strobe and page each page address produces afterwards. The bench drives all 256 data values through a full write cycle on the shared port. After each write it probes all four pages, both as processor accesses and as video fetches, so any mis-decoded write shows up as a wrong bank or page. Writes with the right data but the wrong address, or with `iorq_n` high, are interleaved so that they would overwrite a known configuration if they were wrongly taken.

// File: rtl/bank_latch_pkg.sv
package bank_latch_pkg;
  localparam int PAGE_W = 2;
  localparam int CFG_W  = 3;

  typedef struct packed {
    logic              ext;
    logic [PAGE_W-1:0] page;
  } bank_sel_t;

  function automatic bank_sel_t map_page(input logic [CFG_W-1:0] cfg,
                                         input logic [PAGE_W-1:0] p);
    bank_sel_t r;
    r.ext  = 1'b0;
    r.page = p;
    if (cfg[2]) begin
      if (p == 2'd1) begin
        r.ext  = 1'b1;
        r.page = cfg[1:0];
      end
    end else begin
      case (cfg[1:0])
        2'd1: if (p == 2'd3) r.ext = 1'b1;
        2'd2: r.ext = 1'b1;
        2'd3: begin
          if (p == 2'd1) r.page = 2'd3;
          if (p == 2'd3) r.ext  = 1'b1;
        end
        default: ;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/io_snoop.sv
module io_snoop #(
  parameter int DATA_W = 8,
  parameter int CFG_W  = 3,
  parameter logic [1:0] PORT_SEL = 2'b01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr_hi,
  input  logic [DATA_W-1:0] data,
  input  logic              iorq_n,
  input  logic              wr_n,
  output logic [CFG_W-1:0]  cfg_q
);
  logic wr_prev;
  logic wr_rise;
  logic hit;
  logic unused_bits;

  assign unused_bits = ^data[DATA_W-3:CFG_W];
  assign wr_rise = wr_n && !wr_prev;
  assign hit = wr_rise && !iorq_n && (addr_hi == PORT_SEL) &&
               (data[DATA_W-1:DATA_W-2] == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_prev <= 1'b1;
      cfg_q   <= '0;
    end else begin
      wr_prev <= wr_n;
      if (hit) cfg_q <= data[CFG_W-1:0];
    end
  end
endmodule

// File: rtl/page_mapper.sv
module page_mapper
  import bank_latch_pkg::*;
(
  input  logic [CFG_W-1:0]  cfg,
  input  logic [PAGE_W-1:0] page_in,
  input  logic              video,
  output bank_sel_t         sel
);
  always_comb begin
    if (video) begin
      sel.ext  = 1'b0;
      sel.page = page_in;
    end else begin
      sel = map_page(cfg, page_in);
    end
  end
endmodule

// File: rtl/strobe_steer.sv
module strobe_steer
  import bank_latch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  bank_sel_t         sel,
  input  logic              cas_n,
  input  logic              ram_off,
  output logic [PAGE_W-1:0] page_q,
  output logic              cas0_q,
  output logic              cas1_q
);
  logic strobe_on;
  assign strobe_on = !cas_n && !ram_off;

  always_ff @(posedge clk) begin
    if (rst) begin
      page_q <= '0;
      cas0_q <= 1'b1;
      cas1_q <= 1'b1;
    end else begin
      page_q <= sel.page;
      cas0_q <= !(strobe_on && !sel.ext);
      cas1_q <= !(strobe_on && sel.ext);
    end
  end
endmodule

// File: rtl/ram_bank_latch.sv
module ram_bank_latch
  import bank_latch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cpu_addr_hi,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              iorq_n,
  input  logic              wr_n,
  input  logic              cas_n,
  input  logic              ram_off,
  input  logic              vid_fetch,
  output logic              dram_a15,
  output logic              dram_a14,
  output logic              cas_base_n,
  output logic              cas_ext_n
);
  logic [CFG_W-1:0]  cfg_q;
  bank_sel_t         sel;
  logic [PAGE_W-1:0] page_q;

  io_snoop #(.DATA_W(DATA_W), .CFG_W(CFG_W), .PORT_SEL(2'b01)) u_snoop (
    .clk(clk), .rst(rst), .addr_hi(cpu_addr_hi), .data(cpu_data),
    .iorq_n(iorq_n), .wr_n(wr_n), .cfg_q(cfg_q)
  );

  page_mapper u_map (
    .cfg(cfg_q), .page_in(cpu_addr_hi), .video(vid_fetch), .sel(sel)
  );

  strobe_steer u_steer (
    .clk(clk), .rst(rst), .sel(sel), .cas_n(cas_n), .ram_off(ram_off),
    .page_q(page_q), .cas0_q(cas_base_n), .cas1_q(cas_ext_n)
  );

  assign dram_a15 = page_q[1];
  assign dram_a14 = page_q[0];
endmodule

// File: rtl/bank_latch_chk.sv
module bank_latch_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] cpu_addr_hi,
  input logic [7:0] cpu_data,
  input logic       iorq_n,
  input logic       wr_n,
  input logic       cas_n,
  input logic       ram_off,
  input logic       vid_fetch,
  input logic       dram_a15,
  input logic       dram_a14,
  input logic       cas_base_n,
  input logic       cas_ext_n,
  input logic [2:0] cfg_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (cfg_q == 3'd0 && cas_base_n && cas_ext_n));
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!cas_base_n && !cas_ext_n));
  // R8
  ram_off_chk: assert property (@(posedge clk) disable iff (rst)
    ram_off |=> (cas_base_n && cas_ext_n));
  // R9
  cas_idle_chk: assert property (@(posedge clk) disable iff (rst)
    cas_n |=> (cas_base_n && cas_ext_n));
  // R7
  video_base_chk: assert property (@(posedge clk) disable iff (rst)
    (vid_fetch && !cas_n && !ram_off) |=>
      (!cas_base_n && {dram_a15, dram_a14} == $past(cpu_addr_hi)));
  // R3
  foreign_data_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_n) && !iorq_n && cpu_addr_hi == 2'b01 && cpu_data[7:6] != 2'b11)
      |=> $stable(cfg_q));
  // R4
  foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(wr_n) && (iorq_n || cpu_addr_hi != 2'b01)) |=> $stable(cfg_q));
endmodule

bind ram_bank_latch bank_latch_chk u_chk (
  .clk(clk), .rst(rst), .cpu_addr_hi(cpu_addr_hi), .cpu_data(cpu_data),
  .iorq_n(iorq_n), .wr_n(wr_n), .cas_n(cas_n), .ram_off(ram_off),
  .vid_fetch(vid_fetch), .dram_a15(dram_a15), .dram_a14(dram_a14),
  .cas_base_n(cas_base_n), .cas_ext_n(cas_ext_n), .cfg_q(cfg_q)
);

// File: tb/test_ram_bank_latch.sv
module test_ram_bank_latch;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cpu_addr_hi = 2'b00;
  logic [7:0] cpu_data = 8'h00;
  logic       iorq_n = 1'b1;
  logic       wr_n = 1'b1;
  logic       cas_n = 1'b1;
  logic       ram_off = 1'b0;
  logic       vid_fetch = 1'b0;
  logic       dram_a15, dram_a14, cas_base_n, cas_ext_n;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [2:0] model_cfg = 3'd0;

  always #10 clk = ~clk;

  ram_bank_latch i_ram_bank_latch (
    .clk(clk), .rst(rst), .cpu_addr_hi(cpu_addr_hi), .cpu_data(cpu_data),
    .iorq_n(iorq_n), .wr_n(wr_n), .cas_n(cas_n), .ram_off(ram_off),
    .vid_fetch(vid_fetch), .dram_a15(dram_a15), .dram_a14(dram_a14),
    .cas_base_n(cas_base_n), .cas_ext_n(cas_ext_n)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      failures = failures + 1;
      $display("FAIL %s actual={a15,a14,cas0,cas1}=%b expected=%b", req, act, exp);
    end
  endtask

  // expected {page, cas0_n, cas1_n} from the mapping rules
  function automatic logic [3:0] expect_out(input logic [2:0] cfg, input logic [1:0] p,
                                            input logic vid, input logic active);
    logic       ext;
    logic [1:0] pg;
    ext = 1'b0;
    pg  = p;
    if (!vid) begin
      if (cfg >= 3'd4) begin
        if (p == 2'd1) begin ext = 1'b1; pg = 2'(cfg - 3'd4); end
      end else if (cfg == 3'd1) begin
        ext = (p == 2'd3);
      end else if (cfg == 3'd2) begin
        ext = 1'b1;
      end else if (cfg == 3'd3) begin
        if (p == 2'd1) pg = 2'd3;
        ext = (p == 2'd3);
      end
    end
    if (!active) return {pg, 2'b11};
    return {pg, ext, !ext};
  endfunction

  task automatic io_write(input logic [1:0] a, input logic [7:0] d, input logic iorq);
    @(negedge clk);
    cpu_addr_hi = a; cpu_data = d; iorq_n = iorq; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    iorq_n = 1'b1;
    if (a == 2'b01 && !iorq && d[7:6] == 2'b11) model_cfg = d[2:0];
  endtask

  task automatic access(input string req, input logic [1:0] p, input logic vid,
                        input logic off, input logic cas);
    @(negedge clk);
    cpu_addr_hi = p; vid_fetch = vid; ram_off = off; cas_n = cas;
    @(posedge clk);
    #1;
    check(req, {dram_a15, dram_a14, cas_base_n, cas_ext_n},
          expect_out(model_cfg, p, vid, !off && !cas));
    @(negedge clk);
    cas_n = 1'b1; ram_off = 1'b0; vid_fetch = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {dram_a15, dram_a14, cas_base_n, cas_ext_n}, 4'b0011);
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < 4; p++) access("R1", 2'(p), 1'b0, 1'b0, 1'b0);

    // R2 R5: config written with extra bits set
    io_write(2'b01, 8'hFD, 1'b0);
    access("R5", 2'd1, 1'b0, 1'b0, 1'b0);
    io_write(2'b01, 8'hC2, 1'b0);
    access("R2", 2'd0, 1'b0, 1'b0, 1'b0);
    // R3: gate array data is ignored
    io_write(2'b01, 8'h87, 1'b0);
    access("R3", 2'd0, 1'b0, 1'b0, 1'b0);
    // R4: wrong address and no I/O request
    for (int a = 0; a < 4; a++) begin
      if (a != 1) begin
        io_write(2'(a), 8'hC5, 1'b0);
        access("R4", 2'd1, 1'b0, 1'b0, 1'b0);
      end
    end
    io_write(2'b01, 8'hC5, 1'b1);
    access("R4", 2'd1, 1'b0, 1'b0, 1'b0);
    // R8 R9
    access("R8", 2'd3, 1'b0, 1'b1, 1'b0);
    access("R9", 2'd3, 1'b0, 1'b0, 1'b1);

    // full sweep of data values, all pages, cpu and video
    for (int d = 0; d < 256; d++) begin
      io_write(2'b01, 8'(d), 1'b0);
      for (int p = 0; p < 4; p++) begin
        access((d[7:6] == 2'b11) ? ((d[5:3] != 0) ? "R5" : "R6") : "R3",
               2'(p), 1'b0, 1'b0, 1'b0);
        access("R7", 2'(p), 1'b1, 1'b0, 1'b0);
      end
      if (d % 16 == 0) begin
        access("R8", 2'd1, 1'b0, 1'b1, 1'b0);
        access("R10", 2'd3, 1'b1, 1'b0, 1'b0);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule